// File: doc/BRIEF.md
# Framed Pseudo-Random Chip Generator

This block drives the chopping path of a random-demodulation compressive receiver. A ten-stage shift register with XOR feedback produces one pseudo-random chip per enabled clock. Each chip is given both as a single bit and as a signed bipolar value (+1 or -1), ready for a multiplying mixer. The two forms are registered together, so they stay aligned.

The chip stream is cut into frames of a fixed length. A chip index marks the position within the frame. Two markers flag the first and the last chip of each frame. At every frame boundary the shift register is reloaded from a seed, so every frame carries the same pattern until a new seed is supplied. A seed strobed in while running is held back until the next boundary. A synchronous reset restarts the sequence at once from the seed present on the seed input. An all-zero seed would lock the register, so it is replaced by a fixed nonzero default.

Top module: `chip_seq_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs go to `chip_o`=0, `chip_bip_o`=-1 (2'b11), `chip_idx_o`=0, `frame_start_o`=0 and `frame_end_o`=0.
- R2: Number the stages 1 to 10; stage 10 drives the output. The first chip of a frame (index 0) is stage 10 of the seed, which is seed bit 9. On each enabled edge that is not a frame boundary, the register shifts toward stage 10, and stage 1 takes the XOR of stages 10 and 7. The chip is presented on `chip_o` after the enabled edge that emits it.
- R3: `chip_bip_o` is a 2-bit two's-complement value, valid in the same cycle as `chip_o`: +1 (2'b01) when `chip_o` is 1, and -1 (2'b11) when it is 0.
- R4: `chip_idx_o` gives the position of the presented chip within its frame. It counts 0 to 1023 on enabled edges and wraps to 0.
- R5: `frame_start_o` is high exactly when the presented chip has index 0. `frame_end_o` is high exactly when it has index 1023.
- R6: After the chip with index 1023 is emitted, the register is reloaded from the active seed. Without a new seed, every frame repeats the same 1024 chips.
- R7: A pulse on `seed_ld` captures `seed_i` as the pending seed. It has no effect on the rest of the current frame, and the next frame starts from it. A pulse on the same edge that emits index 1023 already applies to the next frame.
- R8: A seed value of zero, whether loaded by reset or by `seed_ld`, is replaced by the default seed 10'h001.
- R9: While `en` is low, the outputs and the sequence position hold. A `seed_ld` pulse is still captured.
- R10: Asserting `rst` in the middle of a frame restarts at index 0 from `seed_i`, taking effect on that edge without waiting for the frame boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock |
| rst | input | 1 | Synchronous active-high restart from `seed_i` |
| en | input | 1 | Advance the sequence by one chip |
| seed_i | input | 10 | Seed value |
| seed_ld | input | 1 | Capture `seed_i` as pending seed |
| chip_o | output | 1 | Current chip as a bit |
| chip_bip_o | output | 2 | Current chip as signed +1/-1 |
| frame_start_o | output | 1 | Presented chip is first of frame |
| frame_end_o | output | 1 | Presented chip is last of frame |
| chip_idx_o | output | 10 | Position of presented chip in frame |

## Verification
The assertions assume that `rst` is high at the first clock edge, so the seed holder and the shift register start from a defined nonzero value. They also assume that `en`, `seed_ld` and `seed_i` are settled away from the clock edge. The stimulus holds reset at time zero. It changes every input only on the falling edge. It covers zero seeds, loads in mid-frame, a load on the boundary edge, a load during an enable pause, and reset in mid-frame. A reference model in the bench follows every edge and checks all five outputs at each edge.

// File: rtl/chipgen_pkg.sv
package chipgen_pkg;

    localparam int              CG_LFSR_W       = 10;
    localparam int              CG_FRAME_LEN    = 1024;
    localparam logic [9:0]      CG_TAPS         = 10'h240;  // stages 10 and 7
    localparam logic [9:0]      CG_DEFAULT_SEED = 10'h001;

    typedef struct packed {
        logic               bit_v;
        logic signed [1:0]  bip;
    } chip_t;

    function automatic chip_t make_chip(input logic b);
        chip_t r;
        r.bit_v = b;
        r.bip   = b ? 2'sb01 : 2'sb11;
        return r;
    endfunction

endpackage

// File: rtl/seed_stage.sv
module seed_stage #(
    parameter int               W            = chipgen_pkg::CG_LFSR_W,
    parameter logic [W-1:0]     DEFAULT_SEED = chipgen_pkg::CG_DEFAULT_SEED
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] seed_i,
    input  logic         seed_ld,
    output logic [W-1:0] load_val_o
);
    logic [W-1:0] clean;
    logic [W-1:0] staged_q;
    logic         take;

    assign clean      = (seed_i == '0) ? DEFAULT_SEED : seed_i;
    assign take       = rst | seed_ld;
    assign load_val_o = take ? clean : staged_q;

    always_ff @(posedge clk) begin
        if (take) staged_q <= clean;
    end

    // R8
    seed_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        staged_q != '0);

endmodule

// File: rtl/chip_lfsr.sv
module chip_lfsr #(
    parameter int           W    = chipgen_pkg::CG_LFSR_W,
    parameter logic [W-1:0] TAPS = chipgen_pkg::CG_TAPS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         reload,
    input  logic [W-1:0] load_val,
    output logic         chip_bit_o
);
    logic [W-1:0] state_q;
    logic         fb;

    assign fb         = ^(state_q & TAPS);
    assign chip_bit_o = state_q[W-1];

    always_ff @(posedge clk) begin
        if (rst || (en && reload)) state_q <= load_val;
        else if (en)               state_q <= {state_q[W-2:0], fb};
    end

    // R2
    lfsr_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !reload) |=> state_q[W-1:1] == $past(state_q[W-2:0]));
    // R8
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
    parameter int LEN   = chipgen_pkg::CG_FRAME_LEN,
    localparam int IW   = $clog2(LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [IW-1:0] idx_o,
    output logic          last_o
);
    localparam logic [IW-1:0] LAST = IW'(LEN - 1);

    assign last_o = (idx_o == LAST);

    always_ff @(posedge clk) begin
        if (rst)         idx_o <= '0;
        else if (en)     idx_o <= last_o ? '0 : idx_o + 1'b1;
    end

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && idx_o != LAST) |=> idx_o == $past(idx_o) + 1'b1);
    // R6
    idx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && idx_o == LAST) |=> idx_o == '0);

endmodule

// File: rtl/chip_seq_gen.sv
module chip_seq_gen #(
    parameter int                   LFSR_W       = chipgen_pkg::CG_LFSR_W,
    parameter int                   FRAME_LEN    = chipgen_pkg::CG_FRAME_LEN,
    parameter logic [LFSR_W-1:0]    TAPS         = chipgen_pkg::CG_TAPS,
    parameter logic [LFSR_W-1:0]    DEFAULT_SEED = chipgen_pkg::CG_DEFAULT_SEED,
    localparam int                  IDX_W        = $clog2(FRAME_LEN)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [LFSR_W-1:0]        seed_i,
    input  logic                     seed_ld,
    output logic                     chip_o,
    output logic signed [1:0]        chip_bip_o,
    output logic                     frame_start_o,
    output logic                     frame_end_o,
    output logic [IDX_W-1:0]         chip_idx_o
);
    import chipgen_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    logic [LFSR_W-1:0] load_val;
    logic              raw_bit;
    logic [IDX_W-1:0]  pos;
    logic              at_last;
    chip_t             out_q;

    seed_stage #(.W(LFSR_W), .DEFAULT_SEED(DEFAULT_SEED)) u_seed (
        .clk(clk), .rst(rst), .seed_i(seed_i), .seed_ld(seed_ld),
        .load_val_o(load_val)
    );

    chip_lfsr #(.W(LFSR_W), .TAPS(TAPS)) u_lfsr (
        .clk(clk), .rst(rst), .en(en), .reload(at_last),
        .load_val(load_val), .chip_bit_o(raw_bit)
    );

    frame_counter #(.LEN(FRAME_LEN)) u_cnt (
        .clk(clk), .rst(rst), .en(en), .idx_o(pos), .last_o(at_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q         <= make_chip(1'b0);
            frame_start_o <= 1'b0;
            frame_end_o   <= 1'b0;
            chip_idx_o    <= '0;
        end else if (en) begin
            out_q         <= make_chip(raw_bit);
            frame_start_o <= (pos == '0);
            frame_end_o   <= at_last;
            chip_idx_o    <= pos;
        end
    end

    assign chip_o     = out_q.bit_v;
    assign chip_bip_o = out_q.bip;

    // R3
    bipolar_match_chk: assert property (@(posedge clk) disable iff (rst)
        chip_bip_o == (chip_o ? 2'sb01 : 2'sb11));
    // R5
    start_mark_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> chip_idx_o == '0);
    // R5
    end_mark_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end_o |-> chip_idx_o == LAST_IDX);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(chip_idx_o) && $stable(chip_o) && $stable(frame_end_o));

endmodule

// File: tb/chip_seq_gen_test.sv
module chip_seq_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [9:0]  seed_i = 10'h0;
    logic        seed_ld = 1'b0;
    logic        chip_o;
    logic signed [1:0] chip_bip_o;
    logic        frame_start_o, frame_end_o;
    logic [9:0]  chip_idx_o;

    always #10 clk = ~clk;

    chip_seq_gen uut (
        .clk(clk), .rst(rst), .en(en), .seed_i(seed_i), .seed_ld(seed_ld),
        .chip_o(chip_o), .chip_bip_o(chip_bip_o), .frame_start_o(frame_start_o),
        .frame_end_o(frame_end_o), .chip_idx_o(chip_idx_o)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int st[10];
    int staged = 1, midx = 0;
    int e_chip = 0, e_bip = -1, e_start = 0, e_end = 0, e_idx = 0;
    int frame1[1024];

    function automatic int san(input int s);
        return (s == 0) ? 1 : s;
    endfunction

    function automatic int seqbit(input int seed, input int k);
        int r[10];
        int f;
        for (int b = 0; b < 10; b++) r[b] = (seed >> b) & 1;
        for (int n = 0; n < k; n++) begin
            f = r[9] ^ r[6];
            for (int b = 9; b > 0; b--) r[b] = r[b-1];
            r[0] = f;
        end
        return r[9];
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_load(input int s);
        for (int b = 0; b < 10; b++) st[b] = (s >> b) & 1;
    endtask

    task automatic cyc(input bit r, input bit e, input bit l, input int s);
        int nxt;
        int f;
        @(negedge clk);
        rst = r; en = e; seed_ld = l; seed_i = s[9:0];
        @(posedge clk);
        nxt = (r || l) ? san(s) : staged;
        if (r) begin
            staged = nxt; model_load(nxt); midx = 0;
            e_chip = 0; e_bip = -1; e_start = 0; e_end = 0; e_idx = 0;
        end else begin
            staged = nxt;
            if (e) begin
                e_chip = st[9]; e_bip = st[9] ? 1 : -1; e_idx = midx;
                e_start = (midx == 0); e_end = (midx == 1023);
                if (midx == 1023) begin
                    model_load(nxt); midx = 0;
                end else begin
                    f = st[9] ^ st[6];
                    for (int b = 9; b > 0; b--) st[b] = st[b-1];
                    st[0] = f;
                    midx++;
                end
            end
        end
        #5;
        chk("R2", "chip", chip_o, e_chip);
        chk("R3", "bipolar", chip_bip_o, e_bip);
        chk("R4", "index", chip_idx_o, e_idx);
        chk("R5", "start", frame_start_o, e_start);
        chk("R5", "end", frame_end_o, e_end);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int held;
        // R1: reset state
        cyc(1, 0, 0, 10'h2B5);
        cyc(1, 0, 0, 10'h2B5);
        chk("R1", "bipolar", chip_bip_o, -1);
        chk("R1", "index", chip_idx_o, 0);
        chk("R1", "chip", chip_o, 0);
        // frame 1: record
        for (int k = 0; k < 1024; k++) begin
            cyc(0, 1, 0, 0);
            frame1[k] = chip_o;
            if (k < 16) chk("R2", "seq", chip_o, seqbit(10'h2B5, k));
        end
        // R6: frame 2 repeats frame 1
        for (int k = 0; k < 1024; k++) begin
            cyc(0, 1, 0, 0);
            chk("R6", "repeat", chip_o, frame1[k]);
        end
        // R7: load mid-frame has no effect on current frame
        for (int k = 0; k < 300; k++) cyc(0, 1, 0, 0);
        cyc(0, 1, 1, 10'h13C);
        for (int k = 301; k < 1024; k++) begin
            cyc(0, 1, 0, 0);
            chk("R7", "old frame", chip_o, frame1[chip_idx_o]);
        end
        for (int k = 0; k < 16; k++) begin
            cyc(0, 1, 0, 0);
            chk("R7", "new seed", chip_o, seqbit(10'h13C, k));
        end
        // R9: pause holds, load during pause captured
        held = chip_idx_o;
        cyc(0, 0, 1, 10'h0F1);
        for (int k = 0; k < 4; k++) begin
            cyc(0, 0, 0, 0);
            chk("R9", "held index", chip_idx_o, held);
        end
        while (midx != 0) cyc(0, 1, 0, 0);
        for (int k = 0; k < 12; k++) begin
            cyc(0, 1, 0, 0);
            chk("R9", "paused load", chip_o, seqbit(10'h0F1, k));
        end
        // R8 and R10: reset mid-frame with zero seed
        for (int k = 0; k < 200; k++) cyc(0, 1, 0, 0);
        cyc(1, 1, 0, 0);
        chk("R10", "restart index", chip_idx_o, 0);
        for (int k = 0; k < 16; k++) begin
            cyc(0, 1, 0, 0);
            chk("R8", "default seed", chip_o, seqbit(1, k));
        end
        // R10: reset mid-frame with nonzero seed
        cyc(1, 1, 0, 10'h3A7);
        for (int k = 0; k < 16; k++) begin
            cyc(0, 1, 0, 0);
            chk("R10", "restart seq", chip_o, seqbit(10'h3A7, k));
            chk("R10", "restart idx", chip_idx_o, k);
        end
        // R7: load on the boundary edge applies to next frame
        while (midx != 1023) cyc(0, 1, 0, 0);
        cyc(0, 1, 1, 10'h0D2);
        chk("R7", "boundary end", frame_end_o, 1);
        for (int k = 0; k < 16; k++) begin
            cyc(0, 1, 0, 0);
            chk("R7", "boundary seed", chip_o, seqbit(10'h0D2, k));
        end
        // R8: zero seed via load
        while (midx != 1000) cyc(0, 1, 0, 0);
        cyc(0, 1, 1, 0);
        while (midx != 0) cyc(0, 1, 0, 0);
        for (int k = 0; k < 12; k++) begin
            cyc(0, 1, 0, 0);
            chk("R8", "zero load", chip_o, seqbit(1, k));
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule